// File: doc/BRIEF.md
# Serial SAR Converter Link Controller

This block is the host side of a four-wire link to an eight-channel, 10-bit successive-approximation converter. The host pulses `start_i` with a channel number, a conversion-clock mode and a serial-clock divider. The controller lowers chip select and shifts out an 8-bit command, MSB first. It then reads the 10-bit result back and presents it with a one-cycle `done_o` pulse.

There are two conversion-clock modes. In external mode the serial clock keeps running after the command and paces the conversion itself. The converter emits twelve bits, ten data bits followed by two sub-LSB bits, and the controller discards the last two. In internal mode the converter runs its own clock. The controller then holds the serial clock low until the converter's strobe rises, and only after that clocks the result out. A programmable cycle bound guards that wait and ends the transfer with an error pulse if the strobe never arrives.

The converter changes its data output on falling serial-clock edges. The controller samples data on rising edges, after a configurable synchroniser chain. It changes its own data output only on falling edges.

Top module: `sar_link_ctrl`

## Requirements
- R1: After reset and whenever idle, `cs_n_o` is high, `sclk_o` and `din_o` are low, and `busy_o`, `done_o` and `err_o` are low.
- R2: The command is 8 bits sent MSB first on `din_o` and never changes on a rising `sclk_o` edge. Its layout is bit 7 = 1, bits 6:4 = channel, bits 3:2 = 2'b11, and bits 1:0 = 2'b11 for external mode or 2'b10 for internal mode.
- R3: Each high and low phase of `sclk_o` lasts `div_i`+1 system clocks, with the divider latched at start. `sclk_o` idles low. `div_i` must be at least `SYNC_STAGES`.
- R4: External mode (`mode_int_i`=0) produces exactly 21 serial-clock pulses. The converter presents result bits on falls 9 to 20. Data is sampled on rises 10 to 19, and the sub-LSB bits clocked by pulses 20 and 21 are dropped. `result_o` holds the 10 data bits, MSB first.
- R5: In internal mode (`mode_int_i`=1), `sclk_o` stays low after the 8 command pulses until the strobe reads high. Then 11 more pulses follow (19 in total), with data sampled on rises 2 to 11 of that read phase.
- R6: A finished transfer gives one `done_o` pulse carrying `result_o`. The pulse arrives in the cycle in which `busy_o` has fallen and `cs_n_o` has returned high. `done_o` and `err_o` never rise together.
- R7: In internal mode, if the strobe is not seen within `tmo_i`+1 cycles of the wait starting, `err_o` pulses once, no `done_o` is given and the link returns to idle. External mode never times out.
- R8: `start_i` is ignored while `busy_o` is high. Channel, mode, divider and bound are captured when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted when idle |
| mode_int_i | input | 1 | 1 = internal conversion clock, 0 = external |
| chan_i | input | CH_W | Channel number placed in the command |
| div_i | input | DIV_W | Serial-clock half period minus one, in system clocks |
| tmo_i | input | TMO_W | Strobe wait bound, in system clocks minus one |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle result valid pulse |
| err_o | output | 1 | One-cycle strobe timeout pulse |
| result_o | output | DATA_W | Last conversion result |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| din_o | output | 1 | Serial command to the converter |
| dout_i | input | 1 | Serial result from the converter |
| strb_i | input | 1 | Converter strobe |

## Verification
Every channel is converted in both clock modes at two divider settings. Each transfer is checked against a code computed in the bench, so a wrong channel field, a swapped mode field or a bit-slip in either read window each show up as a distinct wrong code. One pass uses extreme and alternating codes (all zeros, all ones, 0x2AA, 0x155) with nonzero sub-LSB bits, which exposes an off-by-one in the capture window or an MSB/LSB reversal. Further runs cover a strobe that never arrives, a tiny bound in external mode, and a second start issued mid-transfer with a different channel and mode.

// File: rtl/sar_link_pkg.sv
package sar_link_pkg;

   localparam int CMD_W = 8;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_WAIT  = 2'd2,
      ST_READ  = 2'd3
   } link_state_t;

   // command word: start flag, channel, fixed input options, clock mode
   function automatic logic [CMD_W-1:0] make_cmd(input logic [2:0] ch, input logic int_mode);
      logic [1:0] md;
      md = int_mode ? 2'b10 : 2'b11;
      return {1'b1, ch, 2'b11, md};
   endfunction

endpackage

// File: rtl/sar_sclk_gen.sv
module sar_sclk_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             sclk_o,
   output logic             rise_o,
   output logic             fall_o
);
   logic [DIV_W-1:0] cnt_q;
   logic             sclk_q;
   logic             tick;

   assign tick   = run_i && (cnt_q == div_i);
   assign rise_o = tick && !sclk_q;
   assign fall_o = tick && sclk_q;
   assign sclk_o = sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (!run_i) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (tick) begin
         cnt_q  <= '0;
         sclk_q <= !sclk_q;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sar_sync.sv
module sar_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] r_q;
         for (genvar k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) r_q[0] <= 1'b0;
                  else        r_q[0] <= d_i;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) r_q[k] <= 1'b0;
                  else        r_q[k] <= r_q[k-1];
               end
            end
         end
         assign q_o = r_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sar_capture.sv
module sar_capture #(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              shift_i,
   input  logic              bit_i,
   output logic [DATA_W-1:0] data_o
);
   logic [DATA_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sh_q <= '0;
      else if (clr_i)   sh_q <= '0;
      else if (shift_i) sh_q <= {sh_q[DATA_W-2:0], bit_i};
   end

   assign data_o = sh_q;
endmodule

// File: rtl/sar_link_fsm.sv
module sar_link_fsm
   import sar_link_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int TMO_W  = 16,
   parameter int DATA_W = 10,
   parameter int SUB_W  = 2,
   parameter int CH_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_int_i,
   input  logic [CH_W-1:0]   chan_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic [TMO_W-1:0]  tmo_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              strb_i,
   input  logic [DATA_W-1:0] cap_i,
   output logic              run_o,
   output logic [DIV_W-1:0]  div_o,
   output logic              clr_o,
   output logic              shift_o,
   output logic              cs_n_o,
   output logic              din_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [DATA_W-1:0] result_o,
   output logic              int_o,
   output logic              wait_o
);
   localparam int EXT_PULSES = CMD_W + 1 + DATA_W + SUB_W;
   localparam int INT_PULSES = DATA_W + 1;
   localparam int CNT_W      = $clog2(EXT_PULSES + 1);
   localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_W - 1);
   localparam logic [CNT_W-1:0] EXT_CAP_LO = CNT_W'(CMD_W + 1);
   localparam logic [CNT_W-1:0] EXT_CAP_HI = CNT_W'(CMD_W + DATA_W);
   localparam logic [CNT_W-1:0] EXT_LAST   = CNT_W'(EXT_PULSES - 1);
   localparam logic [CNT_W-1:0] INT_CAP_LO = CNT_W'(1);
   localparam logic [CNT_W-1:0] INT_CAP_HI = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] INT_LAST   = CNT_W'(INT_PULSES - 1);

   link_state_t        st_q;
   logic [CNT_W-1:0]   fcnt_q;
   logic [TMO_W-1:0]   wcnt_q, tmo_q;
   logic [DIV_W-1:0]   div_q;
   logic [CMD_W-2:0]   cmd_q;
   logic               int_q, cs_q, din_q, done_q, err_q;
   logic [DATA_W-1:0]  res_q;
   logic [CMD_W-1:0]   cmd_new;
   logic               ext_win, int_win;

   assign cmd_new = make_cmd(chan_i[2:0], mode_int_i);
   assign ext_win = (st_q == ST_SHIFT) && !int_q && (fcnt_q >= EXT_CAP_LO) && (fcnt_q <= EXT_CAP_HI);
   assign int_win = (st_q == ST_READ) && (fcnt_q >= INT_CAP_LO) && (fcnt_q <= INT_CAP_HI);

   assign run_o    = (st_q == ST_SHIFT) || (st_q == ST_READ);
   assign div_o    = div_q;
   assign clr_o    = (st_q == ST_IDLE) && start_i;
   assign shift_o  = rise_i && (ext_win || int_win);
   assign cs_n_o   = cs_q;
   assign din_o    = din_q;
   assign busy_o   = (st_q != ST_IDLE);
   assign done_o   = done_q;
   assign err_o    = err_q;
   assign result_o = res_q;
   assign int_o    = int_q;
   assign wait_o   = (st_q == ST_WAIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         fcnt_q <= '0;
         wcnt_q <= '0;
         tmo_q  <= '0;
         div_q  <= '0;
         cmd_q  <= '0;
         int_q  <= 1'b0;
         cs_q   <= 1'b1;
         din_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         res_q  <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_q   <= ST_SHIFT;
                  int_q  <= mode_int_i;
                  div_q  <= div_i;
                  tmo_q  <= tmo_i;
                  din_q  <= cmd_new[CMD_W-1];
                  cmd_q  <= cmd_new[CMD_W-2:0];
                  cs_q   <= 1'b0;
                  fcnt_q <= '0;
               end
            end
            ST_SHIFT: begin
               if (fall_i) begin
                  fcnt_q <= fcnt_q + 1'b1;
                  if (fcnt_q < CMD_LAST) begin
                     din_q <= cmd_q[CMD_W-2];
                     cmd_q <= {cmd_q[CMD_W-3:0], 1'b0};
                  end else if (fcnt_q == CMD_LAST) begin
                     din_q <= 1'b0;
                     if (int_q) begin
                        st_q   <= ST_WAIT;
                        fcnt_q <= '0;
                        wcnt_q <= '0;
                     end
                  end else if (fcnt_q == EXT_LAST) begin
                     st_q   <= ST_IDLE;
                     cs_q   <= 1'b1;
                     done_q <= 1'b1;
                     res_q  <= cap_i;
                  end
               end
            end
            ST_WAIT: begin
               if (strb_i) begin
                  st_q <= ST_READ;
               end else if (wcnt_q == tmo_q) begin
                  st_q  <= ST_IDLE;
                  cs_q  <= 1'b1;
                  err_q <= 1'b1;
               end else begin
                  wcnt_q <= wcnt_q + 1'b1;
               end
            end
            ST_READ: begin
               if (fall_i) begin
                  fcnt_q <= fcnt_q + 1'b1;
                  if (fcnt_q == INT_LAST) begin
                     st_q   <= ST_IDLE;
                     cs_q   <= 1'b1;
                     done_q <= 1'b1;
                     res_q  <= cap_i;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sar_link_ctrl.sv
module sar_link_ctrl #(
   parameter int DIV_W       = 8,
   parameter int TMO_W       = 16,
   parameter int DATA_W      = 10,
   parameter int SUB_W       = 2,
   parameter int CH_W        = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_int_i,
   input  logic [CH_W-1:0]   chan_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic [TMO_W-1:0]  tmo_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [DATA_W-1:0] result_o,
   output logic              cs_n_o,
   output logic              sclk_o,
   output logic              din_o,
   input  logic              dout_i,
   input  logic              strb_i
);
   generate
      if (CH_W != 3) begin : g_bad_ch
         $error("sar_link_ctrl: command word carries exactly 3 channel bits");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("sar_link_ctrl: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("sar_link_ctrl: SYNC_STAGES must lie in 0..3");
      end
      if (DIV_W < 1 || TMO_W < 1) begin : g_bad_w
         $error("sar_link_ctrl: counter widths must be positive");
      end
   endgenerate

   logic              run, rise, fall, clr, shift;
   logic              dout_s, strb_s;
   logic [DIV_W-1:0]  div_lat;
   logic [DATA_W-1:0] cap;
   logic              lat_int, waiting;

   sar_sync #(.STAGES(SYNC_STAGES)) u_sync_dout (
      .clk(clk), .rst_n(rst_n), .d_i(dout_i), .q_o(dout_s)
   );

   sar_sync #(.STAGES(SYNC_STAGES)) u_sync_strb (
      .clk(clk), .rst_n(rst_n), .d_i(strb_i), .q_o(strb_s)
   );

   sar_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
      .clk(clk), .rst_n(rst_n), .run_i(run), .div_i(div_lat),
      .sclk_o(sclk_o), .rise_o(rise), .fall_o(fall)
   );

   sar_capture #(.DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .shift_i(shift),
      .bit_i(dout_s), .data_o(cap)
   );

   sar_link_fsm #(
      .DIV_W(DIV_W), .TMO_W(TMO_W), .DATA_W(DATA_W), .SUB_W(SUB_W), .CH_W(CH_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_int_i(mode_int_i),
      .chan_i(chan_i), .div_i(div_i), .tmo_i(tmo_i),
      .rise_i(rise), .fall_i(fall), .strb_i(strb_s), .cap_i(cap),
      .run_o(run), .div_o(div_lat), .clr_o(clr), .shift_o(shift),
      .cs_n_o(cs_n_o), .din_o(din_o), .busy_o(busy_o), .done_o(done_o),
      .err_o(err_o), .result_o(result_o), .int_o(lat_int), .wait_o(waiting)
   );
endmodule

// File: rtl/sar_link_chk.sv
module sar_link_chk #(
   parameter int DATA_W = 10,
   parameter int SUB_W  = 2
) (
   input logic clk,
   input logic rst_n,
   input logic busy_o,
   input logic done_o,
   input logic err_o,
   input logic cs_n_o,
   input logic sclk_o,
   input logic din_o,
   input logic lat_int,
   input logic waiting
);
   localparam int EXT_N = 8 + 1 + DATA_W + SUB_W;
   localparam int INT_N = 8 + DATA_W + 1;

   logic       sclk_d;
   logic [5:0] pulses;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         pulses <= '0;
      end else begin
         sclk_d <= sclk_o;
         if (!busy_o && !done_o && !err_o) pulses <= '0;
         else if (sclk_o && !sclk_d)       pulses <= pulses + 1'b1;
      end
   end

   assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (cs_n_o && !sclk_o));

   assert_din_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk_o) |-> $stable(din_o));

   assert_ext_pulses_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !lat_int) |-> (pulses == 6'(EXT_N)));

   assert_int_pulses_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && lat_int) |-> (pulses == 6'(INT_N)));

   assert_quiet_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      waiting |-> (!sclk_o && !cs_n_o));

   assert_end_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (done_o || err_o));

   assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, err_o}));

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_err_int_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> lat_int);
endmodule

bind sar_link_ctrl sar_link_chk #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
   .cs_n_o(cs_n_o), .sclk_o(sclk_o), .din_o(din_o), .lat_int(lat_int),
   .waiting(waiting)
);

// File: tb/sar_link_ctrl_tb.sv
module sar_link_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CONV_CYC   = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       mode_int = 1'b0;
   logic [2:0] chan = '0;
   logic [7:0] div = 8'd2;
   logic [15:0] tmo = 16'd1000;
   logic       busy, done, err, cs_n, sclk, din;
   logic [9:0] result;
   logic       dout_m = 1'b0;
   logic       strb_m = 1'b0;

   int pass_cnt = 0;
   int chk_cnt  = 0;

   // converter model and monitors
   logic [9:0]  codes [8];
   logic        no_strobe = 1'b0;
   logic        cs_d = 1'b1, sclk_d = 1'b0;
   int          m_rises = 0, m_falls = 0, rd_falls = 0, wait_rises = 0;
   logic [7:0]  m_byte = '0;
   logic [2:0]  m_chan = '0;
   logic        m_int = 1'b0, pending = 1'b0;
   logic [11:0] word = '0;
   int          conv_cnt = 0;
   int          hi_len = 0, hi_min = 999, hi_max = 0;
   int          ndone = 0, nerr = 0;
   logic [9:0]  last_res = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sar_link_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mode_int_i(mode_int),
      .chan_i(chan), .div_i(div), .tmo_i(tmo), .busy_o(busy), .done_o(done),
      .err_o(err), .result_o(result), .cs_n_o(cs_n), .sclk_o(sclk), .din_o(din),
      .dout_i(dout_m), .strb_i(strb_m)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin ndone++; last_res = result; end
         if (err) nerr++;
         if (cs_n) begin strb_m = 1'b0; dout_m = 1'b0; pending = 1'b0; end
         if (cs_d && !cs_n) begin
            m_rises = 0; m_falls = 0; rd_falls = 0; wait_rises = 0;
            m_byte = '0; m_int = 1'b0; pending = 1'b0;
            hi_len = 0; hi_min = 999; hi_max = 0;
         end
         if (!cs_n) begin
            if (sclk && !sclk_d) begin
               if (pending) wait_rises++;
               if (m_rises < 8) m_byte = {m_byte[6:0], din};
               m_rises++;
               if (m_rises == 8) begin
                  m_chan = m_byte[6:4];
                  m_int  = (m_byte[1:0] == 2'b10);
                  word   = {codes[m_chan], ~codes[m_chan][1:0]};
                  if (m_int) begin pending = 1'b1; conv_cnt = CONV_CYC; end
               end
            end
            if (!sclk && sclk_d) begin
               if (hi_len < hi_min) hi_min = hi_len;
               if (hi_len > hi_max) hi_max = hi_len;
               hi_len = 0;
               m_falls++;
               if (!m_int) begin
                  if (m_falls == 8) strb_m = 1'b1;
                  if (m_falls == 9) strb_m = 1'b0;
                  if (m_falls >= 9 && m_falls <= 20) dout_m = word[20-m_falls];
               end else if (strb_m && !pending && m_falls > 8) begin
                  rd_falls++;
                  if (rd_falls <= 12) dout_m = word[12-rd_falls];
               end
            end
            if (sclk) hi_len++;
            if (pending) begin
               if (conv_cnt == 0) begin
                  pending = 1'b0;
                  if (!no_strobe) strb_m = 1'b1;
               end else begin
                  conv_cnt--;
               end
            end
         end
      end
      cs_d   = cs_n;
      sclk_d = sclk;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      chk_cnt++;
      if (ok) pass_cnt++;
      else $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
   endtask

   function automatic logic [7:0] exp_cmd(input int ch, input bit im);
      return {1'b1, 3'(ch), 2'b11, (im ? 2'b10 : 2'b11)};
   endfunction

   task automatic wait_end(input int d0, input int e0);
      int cyc = 0;
      while (ndone == d0 && nerr == e0 && cyc < 20000) begin
         @(posedge clk); #1;
         cyc++;
      end
      @(posedge clk); #1;
   endtask

   task automatic pulse_start(input int ch, input bit im, input int dv, input int tb);
      @(negedge clk);
      chan = 3'(ch); mode_int = im; div = 8'(dv); tmo = 16'(tb); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic convert(input int ch, input bit im, input int dv);
      int d0, e0;
      logic [9:0] expv;
      d0 = ndone; e0 = nerr;
      expv = codes[ch];
      pulse_start(ch, im, dv, 1000);
      wait_end(d0, e0);
      if (im) check(last_res == expv, "R5 internal result", int'(last_res), int'(expv));
      else    check(last_res == expv, "R4 external result", int'(last_res), int'(expv));
      check(m_byte == exp_cmd(ch, im), "R2 command", int'(m_byte), int'(exp_cmd(ch, im)));
      if (im) check(m_rises == 19, "R5 pulse count", m_rises, 19);
      else    check(m_rises == 21, "R4 pulse count", m_rises, 21);
      check(hi_min == dv + 1 && hi_max == dv + 1, "R3 high phase", hi_max, dv + 1);
      if (im) check(wait_rises == 0, "R5 quiet wait", wait_rises, 0);
      check(ndone == d0 + 1 && nerr == e0, "R6 one done", ndone - d0, 1);
      check(cs_n && !busy && !sclk, "R6 back to idle", int'({cs_n, busy, sclk}), 4);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      chk_cnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", pass_cnt, chk_cnt);
      $finish;
   end

   initial begin
      for (int c = 0; c < 8; c++) codes[c] = '0;
      repeat (3) @(posedge clk);
      #1;
      check(cs_n && !sclk && !busy && !done && !err && !din, "R1 in reset",
            int'({cs_n, sclk, busy, done, err, din}), 32);
      @(negedge clk); rst_n = 1'b1;
      repeat (4) @(posedge clk);
      #1;
      check(cs_n && !sclk && !busy && !done && !err && !din, "R1 after reset",
            int'({cs_n, sclk, busy, done, err, din}), 32);

      // sweep: divider x mode x channel
      for (int dv = 2; dv <= 4; dv += 2) begin
         for (int im = 0; im < 2; im++) begin
            for (int c = 0; c < 8; c++) codes[c] = 10'((c * 131 + (dv * 2 + im) * 97 + 3) % 1024);
            for (int c = 0; c < 8; c++) convert(c, im[0], dv);
         end
      end

      // extreme and alternating codes
      for (int c = 0; c < 8; c++) codes[c] = c[0] ? 10'h3FF : 10'h000;
      codes[2] = 10'h2AA;
      codes[5] = 10'h155;
      for (int im = 0; im < 2; im++)
         for (int c = 0; c < 8; c++) convert(c, im[0], 3);

      // R7: strobe never rises in internal mode
      begin
         int d0, e0;
         no_strobe = 1'b1;
         d0 = ndone; e0 = nerr;
         pulse_start(4, 1'b1, 2, 30);
         wait_end(d0, e0);
         check(nerr == e0 + 1, "R7 timeout error", nerr - e0, 1);
         check(ndone == d0, "R7 no done on timeout", ndone - d0, 0);
         check(cs_n && !busy, "R7 idle after timeout", int'({cs_n, busy}), 2);
         no_strobe = 1'b0;
         // R7: external mode ignores a zero bound
         d0 = ndone; e0 = nerr;
         pulse_start(6, 1'b0, 2, 0);
         wait_end(d0, e0);
         check(ndone == d0 + 1 && nerr == e0, "R7 external no timeout", nerr - e0, 0);
         check(last_res == codes[6], "R7 external result", int'(last_res), int'(codes[6]));
      end

      // R8: second start during a transfer
      begin
         int d0, e0;
         for (int c = 0; c < 8; c++) codes[c] = 10'(c * 77 + 200);
         d0 = ndone; e0 = nerr;
         pulse_start(2, 1'b0, 3, 1000);
         repeat (40) @(posedge clk);
         pulse_start(5, 1'b1, 2, 1000);
         wait_end(d0, e0);
         check(last_res == codes[2], "R8 first config kept", int'(last_res), int'(codes[2]));
         check(m_byte == exp_cmd(2, 1'b0), "R8 command unchanged", int'(m_byte), int'(exp_cmd(2, 1'b0)));
         repeat (60) @(posedge clk);
         #1;
         check(ndone == d0 + 1 && !busy && cs_n, "R8 no extra transfer", ndone - d0, 1);
      end

      $display("%0d/%0d checks passed", pass_cnt, chk_cnt);
      $finish;
   end
endmodule